// File: doc/BRIEF.md
# Paper Tape Character Stepper

This block sits on the I/O port bus of a small 4-bit processor and stands in front of a paper tape reader. Software asks for the next character by writing a control nibble with its advance bit low. The block reacts only to the falling edge of that bit, not to its level. On such an edge it drops its ready flag and runs a fixed step interval of 5 ms, which gives 200 characters per second. When the interval ends, it takes one byte from a character source and raises ready again.

Software reads the stored byte as two nibbles on separate port groups, and each nibble comes back inverted. A byte of all ones stands for an empty reader or the end of the tape. A valid/pop handshake models the tape mechanism. A tape-present input reports whether a tape is loaded: loading a tape clears the byte, removing it sets the byte to all ones, and either change cancels a step in progress. The step length is counted in bus clock cycles. It is derived from the clock frequency and rounded up, so the step is never shorter than the nominal 5 ms.

Top module: `tape_stepper`

## Requirements
- R1: After reset the block is not stepping. Ready is 0, so status reads 0x0, and the byte holds 0xFF, so both data ports read 0x0.
- R2: A write to any address 0x40–0x4F sets the advance line to the inverse of data bit 3. A step starts only when the line goes from inactive to active. A second write with bit 3 = 0, with no write of bit 3 = 1 in between, starts nothing.
- R3: An advance edge that arrives while a step is running is ignored. It neither restarts nor extends the step, and it causes no extra pop.
- R4: An accepted advance clears ready on the next clock edge. The step then lasts STEP_CYC = ceil(CLK_HZ × STEP_US / 1e6) clock cycles, and the result becomes visible STEP_CYC edges after the accepting edge.
- R5: A step ends with the byte latched and ready set to 1 when a tape is present and src_valid is high. In that case src_pop is high for exactly the one cycle before the latching edge.
- R6: A step ends with the byte set to 0xFF, ready left at 0 and no pop when no tape is present or src_valid is low.
- R7: A change of tape_present from 0 to 1 sets the byte to 0x00, clears ready and cancels any running step. This change takes priority over an advance and over the end of a step in the same cycle.
- R8: A change of tape_present from 1 to 0 sets the byte to 0xFF, clears ready and cancels any running step. No pop follows.
- R9: With rd_en high, the port groups read as follows:
  - 0x60–0x6F returns the inverted low nibble of the byte.
  - 0x70–0x7F returns the inverted high nibble.
  - 0x40–0x4F returns status, with ready in bit 0 and bits 3:1 at 0.
  - Any other address, or rd_en low, returns 0x0.
- R10: Writes outside 0x40–0x4F have no effect on the advance line or on the stepping state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr | input | 8 | I/O port address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 4 | Write nibble; bit 3 is the advance bit, active low |
| rd_data | output | 4 | Read nibble |
| tape_present | input | 1 | High while a tape is loaded |
| src_valid | input | 1 | Character source holds a byte |
| src_data | input | 8 | Byte offered by the source |
| src_pop | output | 1 | One-cycle take of the offered byte |

## Verification
The bench builds the block with CLK_HZ = 2100 and STEP_US = 5000. These values give a product of 10.5 cycles, so the round-up is checked directly by expecting ready on cycle 11 and not on cycle 10. The step is also short enough that several thousand random cycles cover many completed steps. They also cover advances that land inside a running step, and tape changes that hit exactly on the final step cycle. With the default parameters a step would take 370 cycles, which would allow only a few steps in the same run time.

// File: rtl/tape_stepper.sv
module tape_stepper #(
  parameter int CLK_HZ  = 74000,
  parameter int STEP_US = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] port_addr,
  input  logic       rd_en,
  input  logic       wr_en,
  input  logic [3:0] wr_data,
  output logic [3:0] rd_data,
  input  logic       tape_present,
  input  logic       src_valid,
  input  logic [7:0] src_data,
  output logic       src_pop
);
  localparam longint unsigned PROD = longint'(CLK_HZ) * longint'(STEP_US);
  localparam int STEP_CYC = int'((PROD + 64'd999_999) / 64'd1_000_000);
  localparam int CW = $clog2(STEP_CYC + 1);

  logic [7:0]    byte_q;
  logic          ready_q, step_q, adv_q, tp_q;
  logic [CW-1:0] cnt_q;

  wire wr_ctl  = wr_en && port_addr[7:4] == 4'h4;
  wire tchg    = tape_present != tp_q;
  wire start   = wr_ctl && !wr_data[3] && !adv_q && !step_q && !tchg;
  wire expire  = step_q && cnt_q == '0 && !tchg;
  assign src_pop = expire && tape_present && src_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q  <= 8'hFF;
      ready_q <= 1'b0;
      step_q  <= 1'b0;
      adv_q   <= 1'b0;
      tp_q    <= 1'b0;
      cnt_q   <= '0;
    end else begin
      tp_q <= tape_present;
      if (wr_ctl) adv_q <= !wr_data[3];
      if (tchg) begin
        byte_q  <= tape_present ? 8'h00 : 8'hFF;
        ready_q <= 1'b0;
        step_q  <= 1'b0;
      end else if (expire) begin
        step_q  <= 1'b0;
        byte_q  <= src_pop ? src_data : 8'hFF;
        ready_q <= src_pop;
      end else if (step_q) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (start) begin
        step_q  <= 1'b1;
        ready_q <= 1'b0;
        cnt_q   <= CW'(STEP_CYC - 1);
      end
    end
  end

  always_comb begin
    rd_data = 4'h0;
    if (rd_en)
      case (port_addr[7:4])
        4'h4:    rd_data = {3'b000, ready_q};
        4'h6:    rd_data = ~byte_q[3:0];
        4'h7:    rd_data = ~byte_q[7:4];
        default: rd_data = 4'h0;
      endcase
  end

  p_pop_needs_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (src_valid && tape_present && step_q));
  p_pop_sets_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |=> (ready_q && step_q == 1'b0));
  p_start_clears_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!ready_q && step_q));
  p_busy_ignores_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q && cnt_q != '0 && !tchg && wr_ctl) |=> (step_q && cnt_q == $past(cnt_q) - 1'b1));
  p_removal_blanks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tchg && !tape_present) |=> (byte_q == 8'hFF && !ready_q && !step_q));
  p_insert_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tchg && tape_present) |=> (byte_q == 8'h00 && !ready_q && !step_q));
endmodule

// File: tb/tape_stepper_bench.sv
module tape_stepper_bench;
  localparam int BN = 11; // ceil(2100*5000/1e6) = ceil(10.5)
  logic clk = 0, rst_n = 0;
  logic [7:0] port_addr = 0, src_data = 0;
  logic rd_en = 0, wr_en = 0, tape_present = 0, src_valid = 0;
  logic [3:0] wr_data = 0, rd_data;
  logic src_pop;
  int checks = 0, fails = 0, pops = 0;

  tape_stepper #(.CLK_HZ(2100), .STEP_US(5000)) u_tape_stepper (
    .clk, .rst_n, .port_addr, .rd_en, .wr_en, .wr_data, .rd_data,
    .tape_present, .src_valid, .src_data, .src_pop);

  always #10 clk = ~clk;

  logic [7:0] m_byte; logic m_ready, m_step, m_adv, m_tp; int m_cnt;

  function automatic logic [3:0] exp_rd();
    if (!rd_en) return 4'h0;
    case (port_addr[7:4])
      4'h4: return {3'b000, m_ready};
      4'h6: return ~m_byte[3:0];
      4'h7: return ~m_byte[7:4];
      default: return 4'h0;
    endcase
  endfunction

  function automatic logic exp_pop();
    return tape_present == m_tp && m_step && m_cnt == BN-1 && tape_present && src_valid;
  endfunction

  always @(posedge clk) begin
    if (src_pop) pops <= pops + 1;
    if (!rst_n) begin
      m_byte <= 8'hFF; m_ready <= 0; m_step <= 0; m_adv <= 0; m_tp <= 0; m_cnt <= 0;
    end else begin
      m_tp <= tape_present;
      if (wr_en && port_addr[7:4] == 4'h4) m_adv <= !wr_data[3];
      if (tape_present != m_tp) begin
        m_byte <= tape_present ? 8'h00 : 8'hFF; m_ready <= 0; m_step <= 0;
      end else if (m_step) begin
        if (m_cnt == BN-1) begin
          m_step <= 0;
          m_ready <= exp_pop();
          m_byte <= exp_pop() ? src_data : 8'hFF;
        end else m_cnt <= m_cnt + 1;
      end else if (wr_en && port_addr[7:4] == 4'h4 && !wr_data[3] && !m_adv) begin
        m_step <= 1; m_ready <= 0; m_cnt <= 0;
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic r, input logic w, input logic [3:0] d,
                       input string tag);
    @(negedge clk);
    port_addr = a; rd_en = r; wr_en = w; wr_data = d;
    #1;
    check({tag, " rd_data"}, {4'h0, rd_data}, {4'h0, exp_rd()});
    check({tag, " src_pop"}, {7'h0, src_pop}, {7'h0, exp_pop()});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(8'h00, 0, 0, 4'h0, tag);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int p0;
    process::self().srandom(32'd1234);
    idle(3, "reset");
    rst_n = 1;
    drive(8'h40, 1, 0, 0, "R1"); check("R1 status", {4'h0, rd_data}, 8'h00);
    drive(8'h65, 1, 0, 0, "R1"); check("R1 low", {4'h0, rd_data}, 8'h00);
    drive(8'h7A, 1, 0, 0, "R1"); check("R1 high", {4'h0, rd_data}, 8'h00);
    // R7 tape inserted: byte becomes 0x00
    tape_present = 1; idle(1, "R7");
    drive(8'h60, 1, 0, 0, "R7"); check("R7 low", {4'h0, rd_data}, 8'h0F);
    // R4/R5 advance, with R3 ignored advance inside the step
    src_valid = 1; src_data = 8'hA5; p0 = pops;
    drive(8'h4C, 0, 1, 4'h0, "R2");
    for (int i = 0; i < BN; i++) begin
      if (i == 2) drive(8'h41, 0, 1, 4'h8, "R3");
      else if (i == 3) drive(8'h41, 0, 1, 4'h0, "R3");
      else begin
        drive(8'h40, 1, 0, 0, "R4");
        check("R4 ready low during step", {4'h0, rd_data}, 8'h00);
      end
    end
    drive(8'h40, 1, 0, 0, "R4"); check("R4 ready after step", {4'h0, rd_data}, 8'h01);
    drive(8'h6F, 1, 0, 0, "R9"); check("R9 low", {4'h0, rd_data}, 8'h0A);
    drive(8'h70, 1, 0, 0, "R9"); check("R9 high", {4'h0, rd_data}, 8'h05);
    drive(8'h50, 1, 0, 0, "R9"); check("R9 other", {4'h0, rd_data}, 8'h00);
    check("R3 R5 one pop", 8'(pops - p0), 8'd1);
    // R2 repeated active write is not an edge
    drive(8'h40, 0, 1, 4'h0, "R2"); idle(BN + 3, "R2");
    drive(8'h40, 1, 0, 0, "R2"); check("R2 level no step", {4'h0, rd_data}, 8'h01);
    // R6 source empty
    src_valid = 0; p0 = pops;
    drive(8'h40, 0, 1, 4'h8, "R6"); drive(8'h40, 0, 1, 4'h0, "R6"); idle(BN + 1, "R6");
    drive(8'h40, 1, 0, 0, "R6"); check("R6 ready", {4'h0, rd_data}, 8'h00);
    drive(8'h70, 1, 0, 0, "R6"); check("R6 high", {4'h0, rd_data}, 8'h00);
    check("R6 no pop", 8'(pops - p0), 8'd0);
    // R8 removal mid-step cancels
    src_valid = 1; p0 = pops;
    drive(8'h40, 0, 1, 4'h8, "R8"); drive(8'h40, 0, 1, 4'h0, "R8"); idle(4, "R8");
    tape_present = 0; idle(BN + 3, "R8");
    drive(8'h40, 1, 0, 0, "R8"); check("R8 ready", {4'h0, rd_data}, 8'h00);
    drive(8'h60, 1, 0, 0, "R8"); check("R8 low", {4'h0, rd_data}, 8'h00);
    check("R8 no pop", 8'(pops - p0), 8'd0);
    // R10 writes elsewhere do nothing
    tape_present = 1; idle(2, "R10"); p0 = pops;
    drive(8'h58, 0, 1, 4'h8, "R10"); drive(8'h30, 0, 1, 4'h0, "R10"); idle(BN + 3, "R10");
    drive(8'h60, 1, 0, 0, "R10"); check("R10 byte kept", {4'h0, rd_data}, 8'h0F);
    check("R10 no pop", 8'(pops - p0), 8'd0);
    // random traffic against the bench model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      if ($urandom_range(63) == 0) tape_present = !tape_present;
      src_valid = $urandom_range(3) != 0;
      src_data = 8'($urandom);
      a = {($urandom_range(3) == 0) ? 4'($urandom) : 4'h4 + 4'($urandom_range(3)), 4'($urandom)};
      drive(a, 1'($urandom), 1'($urandom), 4'($urandom), "R9 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule